// File: doc/BRIEF.md
# Host-to-Peripheral Mailbox Bridge

This block joins a host bus to a small local CPU through two one-byte mailboxes. The host drives an input byte towards the local CPU and collects an output byte coming back, through four byte offsets: input data (write), input status, output data (read) and output status. The local CPU sees the same two registers as memory. One 4 KiB page returns the input byte. Two other pages both load the output byte, and only one of them also raises the host interrupt. The local CPU can therefore post a reply quietly, or post it and alert the host.

Every host write access counts as one event and sends a single-cycle interrupt pulse to the local CPU, however long the host holds its strobe. A separate pulse flags the input byte 0x80, which asks the peripheral for a hard reset. A local status byte shows which mailbox is holding unread data. Each host status byte gives the full flag and an overrun flag, which records that an unread byte was overwritten.

The local address reaches the block as its top page bits only, because the offset inside a window does not matter. All logic runs on one clock with an active-low asynchronous reset.

Top module: `mbx_bridge`

## Requirements
- R1: After reset both mailboxes are empty, no overrun is flagged, hostIrq, locIrq and resetReq are low, locStatus is 0x00, and the host status bytes at offsets 1 and 3 read 0x00.
- R2: A host write access is a rising edge of (hostSel and hostWr). An access at offset 0 stores hostWdata in the input register and sets the input-full flag on that clock edge. After that edge, offset 1 reads bit 0 = 1 and locStatus bit 1 = 1.
- R3: Each host write access at offset 0 produces exactly one locIrq pulse, one cycle long, in the cycle after the capturing edge, even when the strobe is held for several cycles. Host writes at offsets 1, 2 and 3 change no state and produce no pulse.
- R4: A local read (locSel=1, locWr=0) with locAddrHi = 0x5 returns the input byte on locRdata in that cycle and clears input-full at the clock edge. Local reads on other pages return 0x00 and leave input-full unchanged.
- R5: A local write with locAddrHi = 0x6 stores locWdata in the output register and sets output-full. It leaves hostIrq unchanged.
- R6: A local write with locAddrHi = 0x7 stores locWdata in the output register, sets output-full and sets hostIrq.
- R7: hostIrq stays high until a host read access (a rising edge of hostSel with hostWr=0) at offset 2. That read returns the output byte on hostRdata and clears both hostIrq and output-full. Reading offset 3 clears neither.
- R8: A write into a full mailbox replaces the stored byte and sets overrun, which is bit 1 of that mailbox's host status byte (offset 1 for input, offset 3 for output). A consumer read of the mailbox clears its overrun bit.
- R9: A host write of 0x80 at offset 0 gives one resetReq pulse, one cycle long, in the cycle after the capturing edge. No other byte produces a pulse.
- R10: locStatus bit 1 is input-full, bit 0 is output-full, and all higher bits are 0. Host status bytes carry full in bit 0 and overrun in bit 1, with all higher bits 0.
- R11: When a mailbox is loaded and drained on the same clock edge, the reader receives the old byte. The new byte is kept, the full flag stays 1 and overrun stays 0. In the output direction, a write to page 0x7 on that edge leaves hostIrq set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access strobe |
| hostWr | input | 1 | Host access is a write when 1 |
| hostAddr | input | 2 | Host byte offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for the current offset |
| hostIrq | output | 1 | Level interrupt to the host |
| locSel | input | 1 | Local access strobe, one access per cycle |
| locWr | input | 1 | Local access is a write when 1 |
| locAddrHi | input | 4 | Local address page (bits 15:12) |
| locWdata | input | 8 | Local write data |
| locRdata | output | 8 | Local read data |
| locStatus | output | 8 | Mailbox full flags for the local CPU |
| locIrq | output | 1 | Single-cycle interrupt pulse to the local CPU |
| resetReq | output | 1 | Single-cycle hard-reset request pulse |

## Verification
The bench holds a host write strobe for several cycles and counts locIrq pulses. A level-triggered design would send a burst of interrupts and overwrite the mailbox with the same byte, setting overrun where none occurred. The bench also loads and drains each mailbox on the same edge. A design with the wrong priority would lose the new byte, clear the full flag, or report a false overrun. It checks that reading the output status leaves the host interrupt set, that local reads on neighbouring pages drain nothing, and that the quiet page never raises the host interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Host-side byte offsets; the order is decoded by the host driver.
  typedef enum logic [1:0] {
    OFF_IN_DATA  = 2'd0,
    OFF_IN_STAT  = 2'd1,
    OFF_OUT_DATA = 2'd2,
    OFF_OUT_STAT = 2'd3
  } hostOff_e;

  // Strobes from control to datapath, all valid for one clock edge.
  typedef struct packed {
    logic loadIn;        // host deposits a byte
    logic drainIn;       // local CPU consumes the input byte
    logic loadOut;       // local CPU deposits a reply
    logic drainOut;      // host consumes the reply
    logic raiseHostIrq;  // reply posted through the alerting page
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [PAGE_W-1:0] IN_PAGE    = 4'h5,
  parameter logic [PAGE_W-1:0] QUIET_PAGE = 4'h6,
  parameter logic [PAGE_W-1:0] IRQ_PAGE   = 4'h7,
  parameter logic [DATA_W-1:0] RESET_CMD  = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              locSel,
  input  logic              locWr,
  input  logic [PAGE_W-1:0] locAddrHi,
  output mbxStrobe_t        strobe,
  output logic              locIrq,
  output logic              resetReq
);

  logic hostWrLvl, hostRdLvl;
  logic wrPrev, rdPrev;
  logic wrEdge, rdEdge;
  logic locRdIn, locWrQuiet, locWrIrq;

  assign hostWrLvl = hostSel & hostWr;
  assign hostRdLvl = hostSel & ~hostWr;

  // An access is counted once, on the rising edge of its strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= hostWrLvl;
      rdPrev <= hostRdLvl;
    end
  end

  assign wrEdge = hostWrLvl & ~wrPrev;
  assign rdEdge = hostRdLvl & ~rdPrev;

  assign locRdIn    = locSel & ~locWr & (locAddrHi == IN_PAGE);
  assign locWrQuiet = locSel &  locWr & (locAddrHi == QUIET_PAGE);
  assign locWrIrq   = locSel &  locWr & (locAddrHi == IRQ_PAGE);

  always_comb begin
    strobe              = '0;
    strobe.loadIn       = wrEdge & (hostAddr == OFF_IN_DATA);
    strobe.drainOut     = rdEdge & (hostAddr == OFF_OUT_DATA);
    strobe.drainIn      = locRdIn;
    strobe.loadOut      = locWrQuiet | locWrIrq;
    strobe.raiseHostIrq = locWrIrq;
  end

  // Pulses to the local side, one cycle after the capturing edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locIrq   <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      locIrq   <= strobe.loadIn;
      resetReq <= strobe.loadIn & (hostWdata == RESET_CMD);
    end
  end

endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strobe,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] locWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] locRdata,
  output logic [DATA_W-1:0] locStatus,
  output logic              hostIrq
);

  localparam int PAD_W = DATA_W - 2;

  logic [DATA_W-1:0] inData, outData;
  logic inFull, inOvr, outFull, outOvr;

  // Input mailbox: host fills, local CPU drains; a fill wins a tie.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inData <= '0;
      inFull <= 1'b0;
      inOvr  <= 1'b0;
    end else begin
      if (strobe.loadIn) inData <= hostWdata;
      if (strobe.loadIn)       inFull <= 1'b1;
      else if (strobe.drainIn) inFull <= 1'b0;
      if (strobe.loadIn && inFull && !strobe.drainIn) inOvr <= 1'b1;
      else if (strobe.drainIn)                        inOvr <= 1'b0;
    end
  end

  // Output mailbox: local CPU fills, host drains; a fill wins a tie.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outFull <= 1'b0;
      outOvr  <= 1'b0;
      hostIrq <= 1'b0;
    end else begin
      if (strobe.loadOut) outData <= locWdata;
      if (strobe.loadOut)       outFull <= 1'b1;
      else if (strobe.drainOut) outFull <= 1'b0;
      if (strobe.loadOut && outFull && !strobe.drainOut) outOvr <= 1'b1;
      else if (strobe.drainOut)                          outOvr <= 1'b0;
      if (strobe.raiseHostIrq)  hostIrq <= 1'b1;
      else if (strobe.drainOut) hostIrq <= 1'b0;
    end
  end

  always_comb begin
    case (hostAddr)
      OFF_IN_STAT:  hostRdata = {{PAD_W{1'b0}}, inOvr, inFull};
      OFF_OUT_DATA: hostRdata = outData;
      OFF_OUT_STAT: hostRdata = {{PAD_W{1'b0}}, outOvr, outFull};
      default:      hostRdata = '0;
    endcase
  end

  assign locRdata  = strobe.drainIn ? inData : '0;
  assign locStatus = {{PAD_W{1'b0}}, inFull, outFull};

endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [PAGE_W-1:0] IN_PAGE    = 4'h5,
  parameter logic [PAGE_W-1:0] QUIET_PAGE = 4'h6,
  parameter logic [PAGE_W-1:0] IRQ_PAGE   = 4'h7,
  parameter logic [DATA_W-1:0] RESET_CMD  = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostIrq,
  input  logic              locSel,
  input  logic              locWr,
  input  logic [PAGE_W-1:0] locAddrHi,
  input  logic [DATA_W-1:0] locWdata,
  output logic [DATA_W-1:0] locRdata,
  output logic [DATA_W-1:0] locStatus,
  output logic              locIrq,
  output logic              resetReq
);

  mbxStrobe_t strobe;

  mbx_ctrl #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .IN_PAGE(IN_PAGE),
    .QUIET_PAGE(QUIET_PAGE), .IRQ_PAGE(IRQ_PAGE), .RESET_CMD(RESET_CMD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .locSel(locSel), .locWr(locWr), .locAddrHi(locAddrHi),
    .strobe(strobe), .locIrq(locIrq), .resetReq(resetReq)
  );

  mbx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .locWdata(locWdata),
    .hostRdata(hostRdata), .locRdata(locRdata), .locStatus(locStatus),
    .hostIrq(hostIrq)
  );

endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter logic [PAGE_W-1:0] IN_PAGE    = 4'h5,
  parameter logic [PAGE_W-1:0] QUIET_PAGE = 4'h6,
  parameter logic [PAGE_W-1:0] IRQ_PAGE   = 4'h7,
  parameter logic [DATA_W-1:0] RESET_CMD  = 8'h80
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostSel,
  input logic              hostWr,
  input logic [1:0]        hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic              hostIrq,
  input logic              locSel,
  input logic              locWr,
  input logic [PAGE_W-1:0] locAddrHi,
  input logic [DATA_W-1:0] locStatus,
  input logic              locIrq,
  input logic              resetReq
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!hostIrq && !locIrq && !resetReq && locStatus == '0));

  // R2
  in_full_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locStatus[1]) |-> $past(hostSel && hostWr && hostAddr == 2'd0));

  // R3
  loc_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    locIrq |=> !locIrq);

  // R3
  loc_irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    locIrq |-> $past(hostSel && hostWr && hostAddr == 2'd0));

  // R4
  in_drain_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locStatus[1]) |-> $past(locSel && !locWr && locAddrHi == IN_PAGE));

  // R5
  quiet_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locSel && locWr && locAddrHi == QUIET_PAGE && !hostIrq) |=> !hostIrq);

  // R6
  host_irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(locSel && locWr && locAddrHi == IRQ_PAGE));

  // R7
  host_irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostIrq) |-> $past(hostSel && !hostWr && hostAddr == 2'd2));

  // R9
  reset_req_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(hostSel && hostWr && hostAddr == 2'd0 && hostWdata == RESET_CMD));

  // R10
  status_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    locStatus[DATA_W-1:2] == '0);

endmodule

bind mbx_bridge mbx_bridge_chk #(
  .DATA_W(DATA_W), .PAGE_W(PAGE_W), .IN_PAGE(IN_PAGE),
  .QUIET_PAGE(QUIET_PAGE), .IRQ_PAGE(IRQ_PAGE), .RESET_CMD(RESET_CMD)
) u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
  .hostAddr(hostAddr), .hostWdata(hostWdata), .hostIrq(hostIrq),
  .locSel(locSel), .locWr(locWr), .locAddrHi(locAddrHi),
  .locStatus(locStatus), .locIrq(locIrq), .resetReq(resetReq)
);

// File: tb/mbx_bridge_bench.sv
`timescale 1ns/1ps
module mbx_bridge_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSel = 1'b0, hostWr = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       hostIrq;
  logic       locSel = 1'b0, locWr = 1'b0;
  logic [3:0] locAddrHi = 4'h0;
  logic [7:0] locWdata = 8'h00;
  logic [7:0] locRdata, locStatus;
  logic       locIrq, resetReq;

  int checks = 0, fails = 0;
  int irqCount = 0, rstReqCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mbx_bridge u_mbx_bridge (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostIrq(hostIrq), .locSel(locSel), .locWr(locWr), .locAddrHi(locAddrHi),
    .locWdata(locWdata), .locRdata(locRdata), .locStatus(locStatus),
    .locIrq(locIrq), .resetReq(resetReq)
  );

  // A one-cycle pulse is seen by exactly one falling edge.
  always @(negedge clk) begin
    if (locIrq)   irqCount++;
    if (resetReq) rstReqCount++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    hostSel = 1'b0; hostWr = 1'b0; locSel = 1'b0; locWr = 1'b0;
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    repeat (hold) @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic locRead(input logic [3:0] pg, output logic [7:0] d);
    @(negedge clk);
    locSel = 1'b1; locWr = 1'b0; locAddrHi = pg;
    #1 d = locRdata;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic locWrite(input logic [3:0] pg, input logic [7:0] d);
    @(negedge clk);
    locSel = 1'b1; locWr = 1'b1; locAddrHi = pg; locWdata = d;
    @(negedge clk);
    idle();
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    hostAddr = 2'd1; #1 check("R1 in status", hostRdata, 8'h00);
    hostAddr = 2'd3; #1 check("R1 out status", hostRdata, 8'h00);
    check("R1 locStatus", locStatus, 8'h00);
    check("R1 hostIrq", hostIrq, 0);
    check("R1 locIrq", locIrq, 0);
    check("R1 resetReq", resetReq, 0);
    locRead(4'h5, v);
    check("R1 empty input byte", v, 8'h00);
  endtask

  task automatic testHostIn();
    logic [7:0] v;
    int base = irqCount;
    hostWrite(2'd0, 8'h5A, 1);
    check("R3 one pulse", irqCount - base, 1);
    check("R2 locStatus bit1", locStatus, 8'h02);
    hostRead(2'd1, v);
    check("R2 in status full", v, 8'h01);
    locRead(4'h5, v);
    check("R4 local read data", v, 8'h5A);
    check("R4 drained locStatus", locStatus, 8'h00);
    hostRead(2'd1, v);
    check("R4 in status empty", v, 8'h00);
  endtask

  task automatic testHeldWrite();
    logic [7:0] v;
    int base = irqCount;
    hostWrite(2'd0, 8'h33, 4);
    check("R3 held strobe one pulse", irqCount - base, 1);
    hostRead(2'd1, v);
    check("R3 held strobe no overrun", v, 8'h01);
    locRead(4'h5, v);
    check("R4 held data", v, 8'h33);
  endtask

  task automatic testIgnoredWrites();
    logic [7:0] v;
    int base = irqCount;
    hostWrite(2'd1, 8'hFF, 1);
    hostWrite(2'd2, 8'hFF, 1);
    hostWrite(2'd3, 8'hFF, 1);
    check("R3 no pulse off 1-3", irqCount - base, 0);
    check("R3 locStatus untouched", locStatus, 8'h00);
    hostRead(2'd1, v); check("R3 in status untouched", v, 8'h00);
    hostRead(2'd3, v); check("R3 out status untouched", v, 8'h00);
  endtask

  task automatic testLocalDecode();
    logic [7:0] v;
    hostWrite(2'd0, 8'h11, 1);
    locRead(4'h4, v);  check("R4 page 4 reads zero", v, 8'h00);
    locRead(4'h8, v);  check("R4 page 8 reads zero", v, 8'h00);
    check("R4 other pages keep full", locStatus, 8'h02);
    locRead(4'h5, v);  check("R4 page 5 data", v, 8'h11);
    check("R4 page 5 drains", locStatus, 8'h00);
  endtask

  task automatic testQuietOut();
    logic [7:0] v;
    locWrite(4'h6, 8'hC3);
    check("R5 no host irq", hostIrq, 0);
    check("R10 locStatus out full", locStatus, 8'h01);
    hostRead(2'd3, v); check("R5 out status", v, 8'h01);
    hostRead(2'd2, v); check("R7 out data", v, 8'hC3);
    hostRead(2'd3, v); check("R7 out drained", v, 8'h00);
  endtask

  task automatic testIrqOut();
    logic [7:0] v;
    locWrite(4'h7, 8'h96);
    check("R6 host irq raised", hostIrq, 1);
    repeat (5) @(negedge clk);
    check("R7 irq holds", hostIrq, 1);
    hostRead(2'd3, v);
    check("R7 status read keeps irq", hostIrq, 1);
    hostRead(2'd2, v);
    check("R6 out data", v, 8'h96);
    check("R7 irq cleared", hostIrq, 0);
    check("R7 out full cleared", locStatus, 8'h00);
  endtask

  task automatic testOverrun();
    logic [7:0] v;
    hostWrite(2'd0, 8'hA1, 1);
    hostWrite(2'd0, 8'hA2, 1);
    hostRead(2'd1, v); check("R8 in overrun", v, 8'h03);
    locRead(4'h5, v);  check("R8 in newest byte", v, 8'hA2);
    hostRead(2'd1, v); check("R8 in overrun cleared", v, 8'h00);
    locWrite(4'h6, 8'h01);
    locWrite(4'h6, 8'h02);
    hostRead(2'd3, v); check("R8 out overrun", v, 8'h03);
    hostRead(2'd2, v); check("R8 out newest byte", v, 8'h02);
    hostRead(2'd3, v); check("R8 out overrun cleared", v, 8'h00);
  endtask

  task automatic testResetCmd();
    logic [7:0] v;
    check("R9 no earlier request", rstReqCount, 0);
    hostWrite(2'd0, 8'h80, 1);
    check("R9 one request", rstReqCount, 1);
    locRead(4'h5, v);
    check("R9 command byte stored", v, 8'h80);
    hostWrite(2'd0, 8'h81, 1);
    check("R9 other byte no request", rstReqCount, 1);
    locRead(4'h5, v);
  endtask

  task automatic testSimultaneous();
    logic [7:0] v;
    hostWrite(2'd0, 8'h44, 1);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = 2'd0; hostWdata = 8'h55;
    locSel = 1'b1; locWr = 1'b0; locAddrHi = 4'h5;
    #1 v = locRdata;
    @(negedge clk); idle(); @(negedge clk);
    check("R11 reader gets old in byte", v, 8'h44);
    hostRead(2'd1, v); check("R11 in full no overrun", v, 8'h01);
    locRead(4'h5, v);  check("R11 new in byte kept", v, 8'h55);
    locWrite(4'h6, 8'h10);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = 2'd2;
    locSel = 1'b1; locWr = 1'b1; locAddrHi = 4'h7; locWdata = 8'h20;
    #1 v = hostRdata;
    @(negedge clk); idle(); @(negedge clk);
    check("R11 host gets old out byte", v, 8'h10);
    check("R11 irq survives tie", hostIrq, 1);
    hostRead(2'd3, v); check("R11 out full no overrun", v, 8'h01);
    hostRead(2'd2, v); check("R11 new out byte kept", v, 8'h20);
    check("R11 irq cleared after", hostIrq, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHostIn();
    testHeldWrite();
    testIgnoredWrites();
    testLocalDecode();
    testQuietOut();
    testIrqOut();
    testOverrun();
    testResetCmd();
    testSimultaneous();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule